// File: doc/BRIEF.md
# Programmable 3x3 Streaming Edge Filter

This block detects edges in a raster video stream. Pixels arrive one per clock on a valid/ready input, each carrying an 8-bit luma sample in its low byte and chroma in its high byte. Only luma enters the computation. Two earlier lines are kept in on-chip line storage, a 3x3 neighbourhood is assembled around each pixel, and two run-time loadable 3x3 kernels produce a horizontal and a vertical gradient. The absolute gradients are added, shaped by a high and a low threshold and optionally inverted, and the result leaves on a valid/ready output stream with neutral chroma and regenerated start-of-frame and end-of-line markers.

Internally the scan walks one row and one column beyond the frame, so the one-pixel lag of the window is drained and every input position produces exactly one output beat. Neighbours that fall outside the frame take the value of the nearest sample inside it. Frame height and width are configuration inputs sampled at each frame start, so sizes up to the line-storage limit can change between frames. A stall on the output freezes the scan, the line storage and the window together.

Top module: `edge_filter_3x3`

## Requirements
- R1: After reset the output stream holds no beat (out_valid low) and the block is ready for the first pixel of a frame (in_ready high).
- R2: A frame of H rows by W columns yields exactly H*W output beats in raster order; each output beat carries 128 in bits [15:8], and the input chroma in bits [15:8] has no effect on any output.
- R3: The output luma at row y, column x is computed from the 3x3 luma neighbourhood rows y-1..y+1, columns x-1..x+1, out-of-frame coordinates clamped to the nearest edge; each kernel tap t = 3*row + col (row 0 top, col 0 left) sits at bits [8t+7:8t] of its coefficient input as a signed value, and the magnitude is |Gx| + |Gy|.
- R4: A magnitude above the high threshold yields 255; otherwise a magnitude below the low threshold yields 0; otherwise the magnitude saturated to 255 is passed.
- R5: With invert set, the output luma is 255 minus the thresholded value.
- R6: out_sof is high only on the first beat of each frame and out_eol only on the last beat of each row.
- R7: While out_valid is high and out_ready low, the output beat stays unchanged and no input pixel is accepted that would need a new output slot; no sample is lost or duplicated.
- R8: Height and width are sampled at the start of each frame; a value of 0 is treated as 1, and frames down to 1x1, one row or one column are processed with full border clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rows | input | 11 | Frame height, sampled at frame start |
| cfg_cols | input | 11 | Frame width, sampled at frame start |
| cfg_kx | input | 72 | Horizontal kernel, nine signed 8-bit taps |
| cfg_ky | input | 72 | Vertical kernel, nine signed 8-bit taps |
| cfg_hi | input | 16 | High threshold |
| cfg_lo | input | 16 | Low threshold |
| cfg_invert | input | 1 | Invert the shaped result |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel |
| in_data | input | 16 | Chroma [15:8], luma [7:0] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_data | output | 16 | Neutral chroma [15:8], edge level [7:0] |
| out_sof | output | 1 | First beat of the frame |
| out_eol | output | 1 | Last beat of a row |

## Verification
A wrong scan position shows at the ports within one row: out_eol lands on the wrong beat, or the beat count per frame differs from H*W at the end of the frame. A line-storage or window fault corrupts the luma of the first beat whose neighbourhood touches the bad entry, usually in the second output row, and a clamping fault shows on the first or last row and column of every frame. Flow-control faults show at the very next stalled cycle as a changed held beat or a dropped or repeated pixel, which shifts every later expected value.

// File: rtl/edge_pkg.sv
package edge_pkg;
  localparam int LUMA_W = 8;
  localparam logic [7:0] CHROMA_NEUTRAL = 8'd128;
  localparam logic [7:0] LUMA_TOP = 8'd255;

  typedef logic [LUMA_W-1:0] luma_t;
  // index 0 = upper row, 1 = middle row, 2 = lower row
  typedef logic [2:0][LUMA_W-1:0] column_t;
  // [row][col], row 0 upper, col 0 left
  typedef logic [2:0][2:0][LUMA_W-1:0] window_t;

  // threshold, saturate and optional inversion of a gradient magnitude
  function automatic luma_t shape_level(input logic [31:0] mag,
                                        input logic [31:0] hi,
                                        input logic [31:0] lo,
                                        input logic        inv);
    luma_t v;
    if (mag > hi)              v = LUMA_TOP;
    else if (mag < lo)         v = '0;
    else if (mag > 32'd255)    v = LUMA_TOP;
    else                       v = mag[7:0];
    return inv ? (LUMA_TOP - v) : v;
  endfunction
endpackage

// File: rtl/edge_scan_ctrl.sv
module edge_scan_ctrl #(
  parameter int MAX_W = 1920,
  parameter int MAX_H = 1080,
  localparam int CNW = $clog2(MAX_W + 1),
  localparam int RNW = $clog2(MAX_H + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RNW-1:0] cfg_rows,
  input  logic [CNW-1:0] cfg_cols,
  input  logic           in_valid,
  input  logic           slot_free,
  output logic           in_ready,
  output logic           scan_step,
  output logic           need_in,
  output logic           need_out,
  output logic           row_live,
  output logic           col_live,
  output logic           row_first,
  output logic           col_first,
  output logic           sof_pos,
  output logic           eol_pos,
  output logic [CNW-1:0] col_pos
);
  logic [RNW-1:0] row_q, rows_q;
  logic [CNW-1:0] col_q, cols_q;
  logic           at_origin;

  function automatic logic [RNW-1:0] fit_rows(input logic [RNW-1:0] v);
    if (v == '0)                 return RNW'(1);
    else if (v > RNW'(MAX_H))    return RNW'(MAX_H);
    else                         return v;
  endfunction

  function automatic logic [CNW-1:0] fit_cols(input logic [CNW-1:0] v);
    if (v == '0)                 return CNW'(1);
    else if (v > CNW'(MAX_W))    return CNW'(MAX_W);
    else                         return v;
  endfunction

  assign at_origin = (row_q == '0) && (col_q == '0);
  assign row_live  = row_q < rows_q;
  assign col_live  = col_q < cols_q;
  assign need_in   = row_live && col_live;
  assign need_out  = (row_q != '0) && (col_q != '0);
  assign in_ready  = need_in && (!need_out || slot_free);
  assign scan_step = (!need_in || in_valid) && (!need_out || slot_free);
  assign row_first = row_q == RNW'(1);
  assign col_first = col_q == '0;
  assign sof_pos   = row_first && (col_q == CNW'(1));
  assign eol_pos   = need_out && (col_q == cols_q);
  assign col_pos   = col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      rows_q <= RNW'(1);
      cols_q <= CNW'(1);
    end else begin
      if (at_origin) begin
        rows_q <= fit_rows(cfg_rows);
        cols_q <= fit_cols(cfg_cols);
      end
      if (scan_step) begin
        if (col_q == cols_q) begin
          col_q <= '0;
          row_q <= (row_q == rows_q) ? '0 : row_q + RNW'(1);
        end else begin
          col_q <= col_q + CNW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/edge_line_store.sv
module edge_line_store
  import edge_pkg::*;
#(
  parameter int MAX_W = 1920,
  localparam int AW  = $clog2(MAX_W),
  localparam int CNW = $clog2(MAX_W + 1)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic           col_live,
  input  logic           row_live,
  input  logic           row_first,
  input  logic [CNW-1:0] col_pos,
  input  luma_t          din,
  output column_t        col_vec
);
  luma_t       near_q [MAX_W];
  luma_t       far_q  [MAX_W];
  logic [AW-1:0] addr;
  luma_t       near_rd, far_rd;

  assign addr    = col_live ? col_pos[AW-1:0] : '0;
  assign near_rd = near_q[addr];
  assign far_rd  = far_q[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      near_q[addr] <= din;
      far_q[addr]  <= near_rd;
    end
  end

  // upper row clamps to the first line, lower row clamps to the last line
  assign col_vec[0] = row_first ? near_rd : far_rd;
  assign col_vec[1] = near_rd;
  assign col_vec[2] = row_live ? din : near_rd;
endmodule

// File: rtl/edge_window.sv
module edge_window
  import edge_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    shift_en,
  input  logic    col_first,
  input  logic    col_live,
  input  column_t col_in,
  output window_t win
);
  column_t left_q, mid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      mid_q  <= '0;
    end else if (shift_en) begin
      mid_q  <= col_in;
      left_q <= col_first ? col_in : mid_q;
    end
  end

  for (genvar r = 0; r < 3; r++) begin : g_row
    assign win[r][0] = left_q[r];
    assign win[r][1] = mid_q[r];
    assign win[r][2] = col_live ? col_in[r] : mid_q[r];
  end
endmodule

// File: rtl/edge_grad_unit.sv
module edge_grad_unit
  import edge_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int TH_W   = 16,
  localparam int PROD_W = LUMA_W + COEF_W + 1,
  localparam int SUM_W  = PROD_W + 4,
  localparam int MAG_W  = SUM_W + 1
) (
  input  window_t             win,
  input  logic [9*COEF_W-1:0] kx,
  input  logic [9*COEF_W-1:0] ky,
  input  logic [TH_W-1:0]     hi,
  input  logic [TH_W-1:0]     lo,
  input  logic                inv,
  output logic [MAG_W-1:0]    mag,
  output luma_t               level
);
  function automatic logic signed [SUM_W-1:0] dot9(input window_t w,
                                                  input logic [9*COEF_W-1:0] k);
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] cf, px;
    acc = '0;
    for (int t = 0; t < 9; t++) begin
      cf  = SUM_W'(signed'(k[t*COEF_W +: COEF_W]));
      px  = SUM_W'(signed'({1'b0, w[t/3][t%3]}));
      acc = acc + cf * px;
    end
    return acc;
  endfunction

  function automatic logic [SUM_W-1:0] abs_of(input logic signed [SUM_W-1:0] v);
    return (v < 0) ? SUM_W'(-v) : SUM_W'(v);
  endfunction

  logic signed [SUM_W-1:0] gx, gy;

  assign gx    = dot9(win, kx);
  assign gy    = dot9(win, ky);
  assign mag   = MAG_W'(abs_of(gx)) + MAG_W'(abs_of(gy));
  assign level = shape_level(32'(mag), 32'(hi), 32'(lo), inv);
endmodule

// File: rtl/edge_filter_3x3.sv
module edge_filter_3x3
  import edge_pkg::*;
#(
  parameter int MAX_W  = 1920,
  parameter int MAX_H  = 1080,
  parameter int COEF_W = 8,
  parameter int TH_W   = 16,
  localparam int CNW   = $clog2(MAX_W + 1),
  localparam int RNW   = $clog2(MAX_H + 1),
  localparam int MAG_W = LUMA_W + COEF_W + 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RNW-1:0]      cfg_rows,
  input  logic [CNW-1:0]      cfg_cols,
  input  logic [9*COEF_W-1:0] cfg_kx,
  input  logic [9*COEF_W-1:0] cfg_ky,
  input  logic [TH_W-1:0]     cfg_hi,
  input  logic [TH_W-1:0]     cfg_lo,
  input  logic                cfg_invert,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [15:0]         in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [15:0]         out_data,
  output logic                out_sof,
  output logic                out_eol
);
  // named internal events, also observed by the bound checker
  logic           slot_free;
  logic           scan_step, scan_need_in, scan_need_out;
  logic           row_live, col_live, row_first, col_first;
  logic           sof_pos, eol_pos;
  logic [CNW-1:0] col_pos;
  column_t        col_vec;
  window_t        win;
  logic [MAG_W-1:0] grad_mag;
  luma_t          grad_pix;
  logic           unused_chroma;

  assign unused_chroma = ^in_data[15:8];
  assign slot_free     = !out_valid || out_ready;

  edge_scan_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rows  (cfg_rows),
    .cfg_cols  (cfg_cols),
    .in_valid  (in_valid),
    .slot_free (slot_free),
    .in_ready  (in_ready),
    .scan_step (scan_step),
    .need_in   (scan_need_in),
    .need_out  (scan_need_out),
    .row_live  (row_live),
    .col_live  (col_live),
    .row_first (row_first),
    .col_first (col_first),
    .sof_pos   (sof_pos),
    .eol_pos   (eol_pos),
    .col_pos   (col_pos)
  );

  edge_line_store #(.MAX_W(MAX_W)) u_lines (
    .clk       (clk),
    .wr_en     (scan_step && scan_need_in),
    .col_live  (col_live),
    .row_live  (row_live),
    .row_first (row_first),
    .col_pos   (col_pos),
    .din       (in_data[7:0]),
    .col_vec   (col_vec)
  );

  edge_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (scan_step && col_live),
    .col_first (col_first),
    .col_live  (col_live),
    .col_in    (col_vec),
    .win       (win)
  );

  edge_grad_unit #(.COEF_W(COEF_W), .TH_W(TH_W)) u_grad (
    .win   (win),
    .kx    (cfg_kx),
    .ky    (cfg_ky),
    .hi    (cfg_hi),
    .lo    (cfg_lo),
    .inv   (cfg_invert),
    .mag   (grad_mag),
    .level (grad_pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (scan_step && scan_need_out) begin
      out_valid <= 1'b1;
      out_data  <= {CHROMA_NEUTRAL, grad_pix};
      out_sof   <= sof_pos;
      out_eol   <= eol_pos;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_filter_chk.sv
module edge_filter_chk #(
  parameter int MAG_W = 22,
  parameter int TH_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_data,
  input logic             out_sof,
  input logic             out_eol,
  input logic             scan_need_out,
  input logic [MAG_W-1:0] grad_mag,
  input logic [7:0]       grad_pix,
  input logic [TH_W-1:0]  cfg_hi,
  input logic [TH_W-1:0]  cfg_lo,
  input logic             cfg_invert
);
  logic seen_q, last_eol_q;
  logic above_hi, below_lo;

  assign above_hi = grad_mag > MAG_W'(cfg_hi);
  assign below_lo = grad_mag < MAG_W'(cfg_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      last_eol_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      seen_q     <= 1'b1;
      last_eol_q <= out_eol;
    end
  end

  assert_reset_empty_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_neutral_chroma_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[15:8] == 8'd128);

  assert_high_clip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    above_hi |-> grad_pix == (cfg_invert ? 8'd0 : 8'd255));

  assert_low_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (below_lo && !above_hi) |-> grad_pix == (cfg_invert ? 8'd255 : 8'd0));

  assert_frame_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_sof && seen_q) |-> last_eol_q);

  assert_hold_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol));

  assert_no_take_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && scan_need_out) |-> !in_ready);
endmodule

bind edge_filter_3x3 edge_filter_chk #(.MAG_W(MAG_W), .TH_W(TH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_sof       (out_sof),
  .out_eol       (out_eol),
  .scan_need_out (scan_need_out),
  .grad_mag      (grad_mag),
  .grad_pix      (grad_pix),
  .cfg_hi        (cfg_hi),
  .cfg_lo        (cfg_lo),
  .cfg_invert    (cfg_invert)
);

// File: tb/test_edge_filter_3x3.sv
module test_edge_filter_3x3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cfg_rows = 11'd1, cfg_cols = 11'd1;
  logic [71:0] cfg_kx = '0, cfg_ky = '0;
  logic [15:0] cfg_hi = 16'hFFFF, cfg_lo = 16'd0;
  logic        cfg_invert = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_sof, out_eol;

  int checks = 0, errors = 0;
  bit hung = 0;
  int kx[9], ky[9];
  int hi_t, lo_t, inv_t;
  int img[0:511];
  int fr_h, fr_w;

  always #10 clk = ~clk;

  edge_filter_3x3 i_edge_filter_3x3 (
    .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .cfg_kx(cfg_kx), .cfg_ky(cfg_ky), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .cfg_invert(cfg_invert), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clip(input int v, input int n);
    return (v < 0) ? 0 : ((v >= n) ? n - 1 : v);
  endfunction

  // expected level from the requirements: clamped neighbourhood, |Gx|+|Gy|, shaping
  function automatic int model_level(input int y, input int x);
    int sx = 0, sy = 0, m, v, p;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        p  = img[clip(y + i - 1, fr_h) * fr_w + clip(x + j - 1, fr_w)];
        sx += kx[i*3+j] * p;
        sy += ky[i*3+j] * p;
      end
    m = (sx < 0 ? -sx : sx) + (sy < 0 ? -sy : sy);
    if (m > hi_t)      v = 255;
    else if (m < lo_t) v = 0;
    else               v = (m > 255) ? 255 : m;
    return (inv_t != 0) ? 255 - v : v;
  endfunction

  task automatic load_cfg();
    for (int t = 0; t < 9; t++) begin
      cfg_kx[t*8 +: 8] = 8'(kx[t]);
      cfg_ky[t*8 +: 8] = 8'(ky[t]);
    end
    cfg_hi = 16'(hi_t);
    cfg_lo = 16'(lo_t);
    cfg_invert = inv_t[0];
  endtask

  task automatic set_sobel();
    kx = '{-1, 0, 1, -2, 0, 2, -1, 0, 1};
    ky = '{-1, -2, -1, 0, 0, 0, 1, 2, 1};
  endtask

  // pat: 0 random, 1 constant, 2 ramp
  task automatic run_frame(input int cr, input int cc, input int pat,
                           input bit stall, input string tag);
    int n, pi = 0, oi = 0, cyc = 0, held = 0, expv;
    bit was_stalled = 0;
    if (hung) return;
    fr_h = (cr == 0) ? 1 : cr;
    fr_w = (cc == 0) ? 1 : cc;
    n = fr_h * fr_w;
    for (int k = 0; k < n; k++)
      img[k] = (pat == 0) ? int'($urandom_range(0, 255)) :
               (pat == 1) ? 77 : (k * 37) % 256;
    cfg_rows = 11'(cr);
    cfg_cols = 11'(cc);
    load_cfg();
    while (oi < n) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        hung = 1;
        check(0, tag, "watchdog expired, beats", oi, n);
        break;
      end
      in_valid  = (pi < n) && ($urandom_range(0, 3) != 0);
      in_data   = {8'($urandom_range(0, 255)), 8'(img[pi < n ? pi : 0])};
      out_ready = (stall && cyc >= 20 && cyc < 30) ? 1'b0 : ($urandom_range(0, 3) != 0);
      #1;
      if (was_stalled)
        check(out_valid && out_data == 16'(held), "R7", "held beat", int'(out_data), held);
      if (in_valid && in_ready) pi++;
      if (out_valid && out_ready) begin
        expv = model_level(oi / fr_w, oi % fr_w);
        check(out_data[7:0] == 8'(expv), tag, $sformatf("level beat %0d", oi),
              int'(out_data[7:0]), expv);
        check(out_data[15:8] == 8'd128, "R2", "chroma", int'(out_data[15:8]), 128);
        check({out_sof, out_eol} == {oi == 0, (oi % fr_w) == fr_w - 1}, "R6",
              $sformatf("sof/eol beat %0d", oi), int'({out_sof, out_eol}),
              int'({oi == 0, (oi % fr_w) == fr_w - 1}));
        oi++;
      end
      was_stalled = out_valid && !out_ready;
      held = int'(out_data);
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1;
    check(!out_valid && pi == n, "R2", "no extra beat, all pixels taken", pi, n);
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    set_sobel();
    hi_t = 65535; lo_t = 0; inv_t = 0;
    load_cfg();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

    run_frame(6, 8, 0, 1, "R3");
    run_frame(4, 4, 1, 0, "R3");
    kx = '{-1, 0, 1, -1, 0, 1, -1, 0, 1};
    ky = '{-1, -1, -1, 0, 0, 0, 1, 1, 1};
    inv_t = 1;
    run_frame(5, 7, 2, 0, "R5");
    run_frame(4, 4, 1, 0, "R5");
    set_sobel();
    inv_t = 0; hi_t = 200; lo_t = 60;
    run_frame(7, 9, 0, 1, "R4");
    hi_t = 65535; lo_t = 0;
    run_frame(1, 1, 0, 0, "R8");
    run_frame(1, 5, 0, 0, "R8");
    run_frame(4, 1, 0, 0, "R8");
    run_frame(0, 3, 0, 0, "R8");
    for (int f = 0; f < 6; f++) begin
      for (int t = 0; t < 9; t++) begin
        kx[t] = int'($urandom_range(0, 15)) - 8;
        ky[t] = int'($urandom_range(0, 15)) - 8;
      end
      hi_t  = int'($urandom_range(100, 600));
      lo_t  = int'($urandom_range(0, 90));
      inv_t = int'($urandom_range(0, 1));
      run_frame(int'($urandom_range(2, 16)), int'($urandom_range(2, 16)), 0, f[0], "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule